// File: doc/BRIEF.md
# Glitch-Free Differential Clock Park Controller

This block sits between a reference clock pair (true and complement) and a pair of tristate-capable output pads. It takes an asynchronous, active-low power-down request. The request is synchronized on the complement clock and must be seen low on two consecutive rising edges of that clock before anything changes. The outputs are then parked on the following falling edge of the complement clock. At that edge the true clock is already high and the complement is already low, so no shortened pulse ever leaves the pins.

Two configuration bits decide the parked pin state. A park-mode bit chooses between two options: true held high with the complement floating, or both pins floating. An output-enable bit floats both pins whenever it is low, and it overrides everything else. Release is also qualified over two rising edges, and clocking resumes on a rising edge of the complement clock, so the first released pulse is full width. Each pin is presented as a value bit and a drive-enable bit. A status output reports that the pair is parked.

Top module: `pdn_gate_top`

## Requirements
- R1: While `rstN` is low, the block is parked: `parked` is 1 and the pins take their parked state for the current mode.
- R2: After `pwrDnReqN` is sampled low on two consecutive rising edges of `clkComp`, `parked` goes to 1 on the next falling edge of `clkComp`, and not earlier.
- R3: A low level on `pwrDnReqN` that is captured by only one rising edge of `clkComp` never parks the outputs.
- R4: Parked with `parkTristate` = 0 and `outEnable` = 1: `trueEn` = 1 and `trueVal` = 1, `compEn` = 0.
- R5: Parked with `parkTristate` = 1: `trueEn` = 0 and `compEn` = 0.
- R6: With `outEnable` = 0, `trueEn` and `compEn` are both 0 at all times, whatever the mode and the park state.
- R7: After `pwrDnReqN` is sampled high on two consecutive rising edges of `clkComp`, `parked` clears on that second rising edge. From then on, `trueVal` follows `clkTrue` and `compVal` follows `clkComp`, with both enables at 1.
- R8: With `parkTristate` = 1 and `outEnable` = 1, `trueEn` returns to 1 within RELEASE_LIMIT rising edges of `clkComp` once `pwrDnReqN` is held high.
- R9: `parked` is 1 exactly while the pins are held in the parked state. When not parked and enabled, the pins carry the clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkTrue | input | 1 | True phase of the reference clock |
| clkComp | input | 1 | Complement phase of the reference clock; clocks all internal state |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDnReqN | input | 1 | Asynchronous active-low power-down request |
| parkTristate | input | 1 | 0: park true high with complement floating; 1: float both |
| outEnable | input | 1 | 0 floats both pins regardless of other settings |
| trueVal | output | 1 | Value driven on the true pin |
| trueEn | output | 1 | Drive enable of the true pin (0 = high impedance) |
| compVal | output | 1 | Value driven on the complement pin |
| compEn | output | 1 | Drive enable of the complement pin (0 = high impedance) |
| parked | output | 1 | Pair is currently held in the parked state |

## Verification
The assertions assume that `clkTrue` is the exact inverse of `clkComp`. They also assume that the configuration bits and the request are steady around the rising edges that sample them. The bench derives `clkTrue` as the inverse of its generated `clkComp`. It changes `pwrDnReqN`, `parkTristate` and `outEnable` only one time unit after a falling edge, well inside the low phase. The release bound is taken to start counting from when the request is held high. The bench never withdraws the request again before that bound has elapsed.

// File: rtl/pdn_gate_pkg.sv
package pdn_gate_pkg;

  // Qualified decisions passed from the control half to the datapath half.
  typedef struct packed {
    logic hold;   // request seen low on the last two sampling edges
    logic wake;   // request seen high on the last two sampling edges
  } gateStrobe_t;

endpackage

// File: rtl/pdn_gate_ctrl.sv
module pdn_gate_ctrl
  import pdn_gate_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic        clkComp,
  input  logic        rstN,
  input  logic        pwrDnReqN,
  output gateStrobe_t strobe
);

  localparam int LAST = SYNC_DEPTH - 1;

  logic [SYNC_DEPTH-1:0] syncQ;

  // Resetting to all zeros means the block comes out of reset in the powered-down state.
  always_ff @(posedge clkComp or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_DEPTH-2:0], pwrDnReqN};
  end

  // The last two stages are two consecutive samples of the request.
  always_comb begin
    strobe.hold = ~syncQ[LAST] & ~syncQ[LAST-1];
    strobe.wake =  syncQ[LAST] &  syncQ[LAST-1];
  end

endmodule

// File: rtl/pdn_gate_datapath.sv
module pdn_gate_datapath
  import pdn_gate_pkg::*;
(
  input  logic        clkTrue,
  input  logic        clkComp,
  input  logic        rstN,
  input  gateStrobe_t strobe,
  input  logic        parkTristate,
  input  logic        outEnable,
  output logic        trueVal,
  output logic        trueEn,
  output logic        compVal,
  output logic        compEn,
  output logic        parkedNow
);

  logic parkNeg;

  // Entry is taken on the falling edge of clkComp only, when true is already high.
  always_ff @(negedge clkComp or negedge rstN) begin
    if (!rstN)            parkNeg <= 1'b1;
    else if (strobe.hold) parkNeg <= 1'b1;
    else if (strobe.wake) parkNeg <= 1'b0;
  end

  // Release takes effect as soon as the wake decision appears, that is on a rising edge.
  assign parkedNow = parkNeg & ~strobe.wake;

  always_comb begin
    trueVal = 1'b0;
    trueEn  = 1'b0;
    compVal = 1'b0;
    compEn  = 1'b0;
    if (outEnable) begin
      if (parkedNow) begin
        trueVal = 1'b1;
        trueEn  = ~parkTristate;
      end else begin
        trueVal = clkTrue;
        trueEn  = 1'b1;
        compVal = clkComp;
        compEn  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pdn_gate_top.sv
module pdn_gate_top
  import pdn_gate_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clkTrue,
  input  logic clkComp,
  input  logic rstN,
  input  logic pwrDnReqN,
  input  logic parkTristate,
  input  logic outEnable,
  output logic trueVal,
  output logic trueEn,
  output logic compVal,
  output logic compEn,
  output logic parked
);

  gateStrobe_t ctrlStrobe;

  pdn_gate_ctrl #(.SYNC_DEPTH(SYNC_DEPTH)) ctrl_i (
    .clkComp  (clkComp),
    .rstN     (rstN),
    .pwrDnReqN(pwrDnReqN),
    .strobe   (ctrlStrobe)
  );

  pdn_gate_datapath dp_i (
    .clkTrue     (clkTrue),
    .clkComp     (clkComp),
    .rstN        (rstN),
    .strobe      (ctrlStrobe),
    .parkTristate(parkTristate),
    .outEnable   (outEnable),
    .trueVal     (trueVal),
    .trueEn      (trueEn),
    .compVal     (compVal),
    .compEn      (compEn),
    .parkedNow   (parked)
  );

endmodule

// File: rtl/pdn_gate_checker.sv
module pdn_gate_checker
  import pdn_gate_pkg::*;
#(
  parameter int RELEASE_LIMIT = 8,
  localparam int CW = $clog2(RELEASE_LIMIT + 2)
) (
  input logic        clkComp,
  input logic        rstN,
  input logic        pwrDnReqN,
  input logic        parkTristate,
  input logic        outEnable,
  input logic        trueVal,
  input logic        trueEn,
  input logic        compEn,
  input logic        parked,
  input gateStrobe_t strobe
);

  logic [CW-1:0] waitCnt;

  // Counts rising edges spent with the request released but the true pin still floating.
  always_ff @(posedge clkComp or negedge rstN) begin
    if (!rstN)
      waitCnt <= '0;
    else if (pwrDnReqN && outEnable && !trueEn) begin
      if (waitCnt != {CW{1'b1}}) waitCnt <= waitCnt + 1'b1;
    end else
      waitCnt <= '0;
  end

  a_r2_hold_parks: assert property (@(posedge clkComp) disable iff (!rstN)
    strobe.hold |-> parked);

  a_r7_wake_releases: assert property (@(posedge clkComp) disable iff (!rstN)
    strobe.wake |-> !parked);

  a_r4_park_true_high: assert property (@(posedge clkComp) disable iff (!rstN)
    (parked && !parkTristate && outEnable) |-> (trueEn && trueVal && !compEn));

  a_r5_park_float_both: assert property (@(posedge clkComp) disable iff (!rstN)
    (parked && parkTristate) |-> (!trueEn && !compEn));

  a_r6_oe_floats: assert property (@(posedge clkComp) disable iff (!rstN)
    !outEnable |-> (!trueEn && !compEn));

  a_r8_release_bound: assert property (@(posedge clkComp) disable iff (!rstN)
    waitCnt < CW'(RELEASE_LIMIT));

endmodule

bind pdn_gate_top pdn_gate_checker chk_i (
  .clkComp     (clkComp),
  .rstN        (rstN),
  .pwrDnReqN   (pwrDnReqN),
  .parkTristate(parkTristate),
  .outEnable   (outEnable),
  .trueVal     (trueVal),
  .trueEn      (trueEn),
  .compEn      (compEn),
  .parked      (parked),
  .strobe      (ctrlStrobe)
);

// File: tb/pdn_gate_top_tb_top.sv
module pdn_gate_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clkComp = 1'b0;
  logic clkTrue;
  logic rstN = 1'b0;
  logic pwrDnReqN = 1'b1;
  logic parkTristate = 1'b0;
  logic outEnable = 1'b1;
  logic trueVal, trueEn, compVal, compEn, parked;

  assign clkTrue = ~clkComp;
  always #(CLK_PERIOD/2) clkComp = ~clkComp;

  pdn_gate_top dut_i (
    .clkTrue(clkTrue), .clkComp(clkComp), .rstN(rstN), .pwrDnReqN(pwrDnReqN),
    .parkTristate(parkTristate), .outEnable(outEnable),
    .trueVal(trueVal), .trueEn(trueEn), .compVal(compVal), .compEn(compEn),
    .parked(parked)
  );

  typedef struct {
    int    idx;
    bit    expPark;
    bit    tm;
    bit    oe;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int halfIdx = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Driver side: queue what each later half cycle must show.
  task automatic pushRange(input int fromIdx, input int toIdx, input bit p, input string tag);
    for (int i = fromIdx; i <= toIdx; i++) begin
      expItem_t it;
      it.idx = i; it.expPark = p; it.tm = parkTristate; it.oe = outEnable; it.tag = tag;
      expQ.push_back(it);
    end
  endtask

  task automatic waitNeg(output int h);
    @(negedge clkComp);
    #1;
    h = halfIdx;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clkComp);
  endtask

  // Monitor side: every edge, compare against the queued expectation.
  always @(posedge clkComp or negedge clkComp) begin
    halfIdx = halfIdx + 1;
    #2;
    while (expQ.size() > 0 && expQ[0].idx <= halfIdx) begin
      expItem_t it;
      bit eTe, eTv, eCe, eCv;
      it = expQ.pop_front();
      checks++;
      if (!it.oe) begin
        eTe = 0; eTv = 0; eCe = 0; eCv = 0;
      end else if (it.expPark) begin
        eTe = !it.tm; eTv = 1; eCe = 0; eCv = 0;
      end else begin
        eTe = 1; eTv = ~clkComp; eCe = 1; eCv = clkComp;
      end
      if (it.idx < halfIdx) begin
        errors++;
        $display("FAIL %s: item %0d missed at %0d (actual none, expected sample)", it.tag, it.idx, halfIdx);
      end else if (parked !== it.expPark || trueEn !== eTe || compEn !== eCe ||
                   (eTe && trueVal !== eTv) || (eCe && compVal !== eCv)) begin
        errors++;
        $display("FAIL %s: half %0d actual park=%b tEn=%b tV=%b cEn=%b cV=%b expected park=%b tEn=%b tV=%b cEn=%b cV=%b",
                 it.tag, halfIdx, parked, trueEn, trueVal, compEn, compVal,
                 it.expPark, eTe, eTv, eCe, eCv);
      end
    end
  end

  initial begin
    int h;
    // R1 and R4: parked during reset, mode 0
    waitNeg(h);
    pushRange(h + 1, h + 2, 1'b1, "R1");
    settle(2);

    // R7 and R9: release out of reset with the request high
    waitNeg(h);
    rstN = 1'b1;
    pushRange(h + 1, h + 2, 1'b1, "R9");
    pushRange(h + 3, h + 6, 1'b0, "R7");
    settle(5);

    // R2 and R4: enter park in mode 0
    waitNeg(h);
    pwrDnReqN = 1'b0;
    pushRange(h + 1, h + 3, 1'b0, "R2");
    pushRange(h + 4, h + 6, 1'b1, "R4");
    settle(5);

    // R7: release from mode 0 park
    waitNeg(h);
    pwrDnReqN = 1'b1;
    pushRange(h + 1, h + 2, 1'b1, "R7");
    pushRange(h + 3, h + 6, 1'b0, "R7");
    settle(5);

    // R3: request low for a single sampling edge only
    waitNeg(h);
    pwrDnReqN = 1'b0;
    pushRange(h + 1, h + 2, 1'b0, "R3");
    settle(1);
    #1;
    pwrDnReqN = 1'b1;
    pushRange(h + 3, h + 8, 1'b0, "R3");
    settle(6);

    // R5: enter park in float-both mode
    waitNeg(h);
    parkTristate = 1'b1;
    pwrDnReqN = 1'b0;
    pushRange(h + 1, h + 3, 1'b0, "R2");
    pushRange(h + 4, h + 6, 1'b1, "R5");
    settle(5);

    // R8: true pin driven again after release in float-both mode
    waitNeg(h);
    pwrDnReqN = 1'b1;
    pushRange(h + 1, h + 2, 1'b1, "R5");
    pushRange(h + 3, h + 6, 1'b0, "R8");
    settle(5);

    // R6: output enable low while running, then while parked in mode 0
    waitNeg(h);
    parkTristate = 1'b0;
    outEnable = 1'b0;
    pushRange(h + 1, h + 2, 1'b0, "R6");
    settle(1);
    #1;
    pwrDnReqN = 1'b0;
    pushRange(h + 3, h + 5, 1'b0, "R6");
    pushRange(h + 6, h + 8, 1'b1, "R6");
    settle(4);

    // R4: enable restored while still parked
    waitNeg(h);
    outEnable = 1'b1;
    pushRange(h + 1, h + 3, 1'b1, "R4");
    settle(3);

    // R7: final release
    waitNeg(h);
    pwrDnReqN = 1'b1;
    pushRange(h + 1, h + 2, 1'b1, "R7");
    pushRange(h + 3, h + 5, 1'b0, "R7");
    settle(5);

    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL queue: actual %0d items left, expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule